// File: doc/BRIEF.md
# Breakpoint Data Byte Comparator

This block holds a programmable match word, split into byte lanes, and compares it each clock against live processor bus activity. When every participating lane agrees and the bus cycle is valid, it raises a one-clock breakpoint request on the following clock. Halting the processor is left to the logic that consumes this request.

A mode input steers the same match word to one of two buses. In full-breakpoint mode each lane is compared with the matching byte of the data bus. In dual-address mode each lane is compared with the matching byte of the address bus, so the word acts as a second address.

Each lane can be masked, which makes it always agree. A data-bus enable decides whether data lanes take part in full mode at all. A global enable silences the block. The match word is written through a byte-strobed write port. It is cleared only by the power-on reset, so it survives the ordinary reset.

Top module: `bkp_data_cmp`

## Requirements
- R1: Power-on reset (`por_n` low) clears the match word to zero and drives `match` low.
- R2: The ordinary reset (`rst_n` low) holds `match` low but leaves the match word unchanged.
- R3: With `dual_mode`=0 and `dbus_en`=1, the high lane (`byte_mask[1]`, word bits 15:8) is compared with `data[15:8]`.
- R4: With `dual_mode`=0 and `dbus_en`=1, the low lane (`byte_mask[0]`, word bits 7:0) is compared with `data[7:0]`.
- R5: With `dual_mode`=1, each lane is compared with the same-position byte of `addr`, and `data` has no effect.
- R6: A lane whose `byte_mask` bit is 1 always agrees, whatever the bus byte.
- R7: With `dual_mode`=0 and `dbus_en`=0, the data lanes do not take part, and every valid cycle matches.
- R8: `match` is high for exactly the one clock after a sampled cycle in which `bus_valid`=1 and all lanes agree. It is low after any cycle in which `bus_valid`=0.
- R9: With `bp_en`=0, `match` stays low whatever the bus contents.
- R10: A cycle with `wr_en`=1 never produces a match. The written value is used from the next cycle on.
- R11: `wr_be[i]`=1 loads byte lane i from `wr_data`. Lanes whose strobe is 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears the match word |
| rst_n | input | 1 | Ordinary reset, synchronous, active low; clears only the output |
| addr | input | 16 | Processor address bus |
| data | input | 16 | Processor data bus |
| bus_valid | input | 1 | Marks a valid bus cycle |
| dual_mode | input | 1 | 0 = compare with data bus, 1 = compare with address bus |
| bp_en | input | 1 | Global breakpoint enable |
| dbus_en | input | 1 | Lets data lanes take part in full-breakpoint mode |
| byte_mask | input | 2 | Per-lane mask; bit 1 = high lane, bit 0 = low lane |
| wr_en | input | 1 | Match-word write strobe |
| wr_be | input | 2 | Byte-lane write enables; bit 1 = high lane |
| wr_data | input | 16 | Match-word write data |
| match | output | 1 | One-clock breakpoint request |

## Verification
The bench writes a word whose two bytes differ. It then presents bus values that differ in only one lane, so a design that swapped lanes, or that ignored one lane, would match where it must not. It drives a matching value in the same cycle as a write, which catches a design that let the write cycle match or that used the old word after the write. It pulses the ordinary reset after loading a word, exposing a design that cleared the word on that reset. It also switches to dual mode with a non-matching data bus, which catches a design that still looked at the data bus in that mode.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
   typedef enum logic {
      MODE_FULL = 1'b0,
      MODE_DUAL = 1'b1
   } bkp_mode_e;
endpackage

// File: rtl/bkp_match_reg.sv
module bkp_match_reg #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_be,
   input  logic [W-1:0]     wr_data,
   output logic [W-1:0]     q
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            q[i*LANE_W +: LANE_W] <= '0;
         else if (wr_en && wr_be[i])
            q[i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end

      // R11: a lane without its strobe keeps its content
      a_r11_lane_hold: assert property (@(posedge clk) disable iff (!por_n)
         !(wr_en && wr_be[i]) |=> $stable(q[i*LANE_W +: LANE_W]));
   end

   // R2: nothing but a write or power-on reset changes the word
   a_r2_word_hold: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/bkp_lane_cmp.sv
module bkp_lane_cmp
   import bkp_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] ref_byte,
   input  logic [LANE_W-1:0] addr_byte,
   input  logic [LANE_W-1:0] data_byte,
   input  bkp_mode_e         mode,
   input  logic              dbus_en,
   input  logic              mask,
   output logic              hit
);
   always_comb begin
      if (mask)
         hit = 1'b1;
      else if (mode == MODE_DUAL)
         hit = (addr_byte == ref_byte);
      else if (!dbus_en)
         hit = 1'b1;
      else
         hit = (data_byte == ref_byte);
   end
endmodule

// File: rtl/bkp_data_cmp.sv
module bkp_data_cmp
   import bkp_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int W     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic [W-1:0]     addr,
   input  logic [W-1:0]     data,
   input  logic             bus_valid,
   input  logic             dual_mode,
   input  logic             bp_en,
   input  logic             dbus_en,
   input  logic [LANES-1:0] byte_mask,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_be,
   input  logic [W-1:0]     wr_data,
   output logic             match
);
   if (LANES < 1) begin : g_bad_lanes
      $error("bkp_data_cmp: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("bkp_data_cmp: LANE_W must be at least 1");
   end

   logic [W-1:0]     word_q;
   logic [LANES-1:0] lane_hit;
   bkp_mode_e        mode;

   assign mode = bkp_mode_e'(dual_mode);

   bkp_match_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_reg (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .q       (word_q)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      bkp_lane_cmp #(.LANE_W(LANE_W)) u_lane (
         .ref_byte  (word_q[i*LANE_W +: LANE_W]),
         .addr_byte (addr[i*LANE_W +: LANE_W]),
         .data_byte (data[i*LANE_W +: LANE_W]),
         .mode      (mode),
         .dbus_en   (dbus_en),
         .mask      (byte_mask[i]),
         .hit       (lane_hit[i])
      );
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         match <= 1'b0;
      else if (!rst_n)
         match <= 1'b0;
      else
         match <= bus_valid && bp_en && !wr_en && (&lane_hit);
   end

   // R8: a request needs a valid cycle one clock earlier
   a_r8_needs_valid: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      match |-> $past(bus_valid));

   // R9: no request while globally disabled
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      match |-> $past(bp_en));

   // R10: a write cycle never yields a request
   a_r10_write_quiet: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $past(wr_en) |-> !match);

   // R6: fully masked, enabled, valid cycles always match
   a_r6_all_masked: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (bus_valid && bp_en && !wr_en && (&byte_mask) && rst_n) |=> match);
endmodule

// File: tb/bkp_data_cmp_tb.sv
module bkp_data_cmp_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [15:0] data = '0;
   logic        bus_valid = 1'b0;
   logic        dual_mode = 1'b0;
   logic        bp_en = 1'b0;
   logic        dbus_en = 1'b0;
   logic [1:0]  byte_mask = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_be = '0;
   logic [15:0] wr_data = '0;
   logic        match;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bkp_data_cmp u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .data(data),
      .bus_valid(bus_valid), .dual_mode(dual_mode), .bp_en(bp_en),
      .dbus_en(dbus_en), .byte_mask(byte_mask), .wr_en(wr_en),
      .wr_be(wr_be), .wr_data(wr_data), .match(match)
   );

   task automatic check(input logic exp, input string req);
      checks++;
      if (match !== exp) begin
         errors++;
         $display("FAIL %s match=%b expected=%b", req, match, exp);
      end
   endtask

   // present one bus cycle, then sample the registered request
   task automatic bus(input logic [15:0] a, input logic [15:0] d,
                      input logic v, input logic exp, input string req);
      @(negedge clk);
      addr = a; data = d; bus_valid = v;
      @(negedge clk);
      check(exp, req);
      bus_valid = 1'b0;
   endtask

   // write the word while a matching cycle is on the bus
   task automatic write_word(input logic [1:0] be, input logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_be = be; wr_data = v;
      bus_valid = 1'b1; addr = v; data = v;
      @(negedge clk);
      check(1'b0, "R10 write cycle");
      wr_en = 1'b0; wr_be = '0; bus_valid = 1'b0;
   endtask

   task automatic t_por;
      por_n = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(1'b0, "R1 reset output");
      por_n = 1'b1; rst_n = 1'b1;
      dual_mode = 1'b0; dbus_en = 1'b1; bp_en = 1'b1; byte_mask = '0;
      bus(16'h0000, 16'h0000, 1'b1, 1'b1, "R1 word cleared");
      bus(16'h0000, 16'h0001, 1'b1, 1'b0, "R1 nonzero data");
   endtask

   task automatic t_valid;
      bus(16'h0000, 16'h0000, 1'b0, 1'b0, "R8 invalid cycle");
      bus(16'h0000, 16'h0000, 1'b1, 1'b1, "R8 valid cycle");
      @(negedge clk);
      check(1'b0, "R8 single pulse");
   endtask

   task automatic t_write;
      write_word(2'b11, 16'hA55A);
      bus(16'h0000, 16'hA55A, 1'b1, 1'b1, "R10 new word used");
   endtask

   task automatic t_full;
      bus(16'h0000, 16'h005A, 1'b1, 1'b0, "R3 high lane differs");
      bus(16'h0000, 16'hA55A, 1'b1, 1'b1, "R3 both lanes agree");
      bus(16'h0000, 16'hA500, 1'b1, 1'b0, "R4 low lane differs");
      bus(16'hA55A, 16'h5AA5, 1'b1, 1'b0, "R3 address ignored in full mode");
   endtask

   task automatic t_mask;
      byte_mask = 2'b10;
      bus(16'h0000, 16'h005A, 1'b1, 1'b1, "R6 high lane masked");
      bus(16'h0000, 16'h0000, 1'b1, 1'b0, "R6 low lane still compared");
      byte_mask = 2'b01;
      bus(16'h0000, 16'hA5FF, 1'b1, 1'b1, "R6 low lane masked");
      byte_mask = 2'b11;
      bus(16'h1234, 16'h4321, 1'b1, 1'b1, "R6 both masked");
      byte_mask = 2'b00;
   endtask

   task automatic t_dbus_off;
      dbus_en = 1'b0;
      bus(16'h0000, 16'h1111, 1'b1, 1'b1, "R7 data lanes off");
      dbus_en = 1'b1;
   endtask

   task automatic t_dual;
      dual_mode = 1'b1;
      bus(16'hA55A, 16'h0000, 1'b1, 1'b1, "R5 address agrees");
      bus(16'hA55B, 16'hA55A, 1'b1, 1'b0, "R5 low address lane differs");
      bus(16'h155A, 16'hA55A, 1'b1, 1'b0, "R5 high address lane differs");
   endtask

   task automatic t_byte_write;
      write_word(2'b01, 16'hFF33);
      bus(16'hA533, 16'h0000, 1'b1, 1'b1, "R11 only low lane written");
      bus(16'hFF33, 16'h0000, 1'b1, 1'b0, "R11 high lane kept");
   endtask

   task automatic t_soft_reset;
      @(negedge clk);
      rst_n = 1'b0; bus_valid = 1'b1; addr = 16'hA533;
      @(negedge clk);
      check(1'b0, "R2 output low in reset");
      rst_n = 1'b1; bus_valid = 1'b0;
      bus(16'hA533, 16'h0000, 1'b1, 1'b1, "R2 word survives reset");
   endtask

   task automatic t_disable;
      bp_en = 1'b0;
      bus(16'hA533, 16'h0000, 1'b1, 1'b0, "R9 disabled");
      byte_mask = 2'b11;
      bus(16'h0000, 16'h0000, 1'b1, 1'b0, "R9 disabled and masked");
      byte_mask = 2'b00; bp_en = 1'b1;
   endtask

   task automatic t_por_again;
      @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1; dual_mode = 1'b0;
      bus(16'h0000, 16'h0000, 1'b1, 1'b1, "R1 power-on clears word");
   endtask

   initial begin
      t_por();
      t_valid();
      t_write();
      t_full();
      t_mask();
      t_dbus_off();
      t_dual();
      t_byte_write();
      t_soft_reset();
      t_disable();
      t_por_again();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule